// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal single-word request bus and a 256K x 4 asynchronous static RAM. It accepts one read or write at a time over a valid/ready handshake and turns it into a timed sequence on the memory pins: an 18-bit address, active-low chip enable, output enable and write enable, and a 4-bit data path split into an outgoing value, a tristate enable and an incoming value.

Every pin phase (address setup before the write strobe, the write strobe itself, the read window and the bus turnaround after a read) lasts a parameterised number of clock cycles. An elaboration-time guard compares each phase length times the clock period against the memory's minimum timings and stops elaboration if one falls short. The write strobe only ever falls inside a chip-enable-low window and rises before chip enable, so the write always ends on the write-enable edge and data setup is counted against that edge. Between accesses the memory stays selected with its outputs off for one cycle; if no request arrives then, chip enable is released and the memory drops into standby.

Read data is captured on the clock edge that closes the read window and returned with a one-cycle valid pulse.

Top module: `sramc_top`

## Requirements
- R1: While reset is held and in the first cycle after it, memCeN, memOeN and memWeN are 1, memDataEn and rspValid are 0, and reqReady is 1.
- R2: For an accepted read, in cycles 1 to READ_CYC after the acceptance edge memCeN=0, memOeN=0, memWeN=1, memDataEn=0 and memAddr equals the request address; memOeN and memWeN are never low together.
- R3: rspValid is high for exactly the one cycle READ_CYC+1 after a read's acceptance edge, and rspData then holds the memDataIn value present at the end of cycle READ_CYC.
- R4: For an accepted write, memCeN=0 and memOeN=1 in cycles 1 to SETUP_CYC+PULSE_CYC+1; memWeN is 1 in cycles 1 to SETUP_CYC, 0 in the next PULSE_CYC cycles, and 1 again in cycle SETUP_CYC+PULSE_CYC+1.
- R5: During a write, memDataEn is 1 and memAddr and memDataOut hold the request's address and data from cycle 1 until the cycle after memWeN rises; memWeN is low only while memCeN is low and memDataEn is high.
- R6: After a read, memOeN=1, memCeN=0 and memDataEn=0 for TURN_CYC cycles; memDataEn is never 1 while the memory's outputs are enabled (memCeN=0, memOeN=0, memWeN=1) nor within TURN_CYC cycles after that.
- R7: Each access ends with one selected-idle cycle (memCeN=0, memOeN=1, memWeN=1, memDataEn=0, reqReady=1); a request accepted in that cycle starts its access with memCeN staying 0.
- R8: If no request is accepted in the selected-idle cycle, memCeN is 1 from the next cycle on, with memOeN=1, memWeN=1 and memDataEn=0, until a request is accepted.
- R9: reqReady is 0 in every cycle of an access; request inputs changed during that time do not alter memAddr or memDataOut.
- R10: A value written to any address, including 0x00000 and 0x3FFFF, is returned by a later read of that address, and writes to other addresses do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 4 | Write data |
| rspValid | output | 1 | One-cycle read data valid pulse |
| rspData | output | 4 | Read data |
| memAddr | output | 18 | Memory address pins |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memDataOut | output | 4 | Data driven toward the memory |
| memDataEn | output | 1 | Tristate enable for memDataOut |
| memDataIn | input | 4 | Data read from the memory I/O pins |

## Verification
All pin outputs are registered, so each one changes on the edge that follows the decision: the first access cycle is the one right after the acceptance edge, the response pulse lands in cycle READ_CYC+1, the selected-idle cycle follows the last phase, and standby starts one cycle after that. The bench counts falling edges from the acceptance edge and compares every pin against the expected phase in each counted cycle, including the response and turnaround cycles. A memory model in the bench commits a write when the write strobe rises and drives read data only while its outputs are enabled, so a wrong capture edge or an overlapping driver shows up as a data or overlap failure.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_READ,
    PH_TURN,
    PH_SEL
  } phase_t;

  typedef struct packed {
    logic chipOn;
    logic outOn;
    logic writeOn;
    logic driveOn;
    logic load;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/sramc_timing_guard.sv
module sramc_timing_guard #(
  parameter int CLK_PERIOD_PS    = 10000,
  parameter int SETUP_CYC        = 1,
  parameter int PULSE_CYC        = 1,
  parameter int READ_CYC         = 2,
  parameter int TURN_CYC         = 1,
  parameter int T_CYCLE_PS       = 12000,
  parameter int T_WE_WIDTH_PS    = 10000,
  parameter int T_ADDR_END_PS    = 10000,
  parameter int T_DATA_END_PS    = 7000,
  parameter int T_FLOAT_PS       = 6000
) ();

  localparam int READ_PS  = READ_CYC * CLK_PERIOD_PS;
  localparam int PULSE_PS = PULSE_CYC * CLK_PERIOD_PS;
  localparam int AEND_PS  = (SETUP_CYC + PULSE_CYC) * CLK_PERIOD_PS;
  localparam int WCYC_PS  = (SETUP_CYC + PULSE_CYC + 1) * CLK_PERIOD_PS;
  localparam int TURN_PS  = TURN_CYC * CLK_PERIOD_PS;

  generate
    if (SETUP_CYC < 1 || PULSE_CYC < 1 || READ_CYC < 1 || TURN_CYC < 1) begin : g_zeroPhase
      $error("every phase must last at least one clock cycle");
    end
    if (READ_PS < T_CYCLE_PS) begin : g_shortRead
      $error("read window shorter than the access time");
    end
    if (PULSE_PS < T_WE_WIDTH_PS) begin : g_shortPulse
      $error("write strobe narrower than its minimum width");
    end
    if (PULSE_PS < T_DATA_END_PS) begin : g_shortData
      $error("data setup before write end too short");
    end
    if (AEND_PS < T_ADDR_END_PS) begin : g_shortAddr
      $error("address setup before write end too short");
    end
    if (WCYC_PS < T_CYCLE_PS) begin : g_shortWrite
      $error("write cycle shorter than its minimum");
    end
    if (TURN_PS < T_FLOAT_PS) begin : g_shortTurn
      $error("turnaround shorter than the output float time");
    end
  endgenerate

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1,
  parameter int READ_CYC  = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int LONG_A  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int LONG_B  = (READ_CYC > TURN_CYC) ? READ_CYC : TURN_CYC;
  localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LOAD  = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD  = CNT_W'(TURN_CYC - 1);

  phase_t           phase, nextPhase;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             lastCycle;
  logic             accept;

  assign lastCycle = (cnt == '0);
  assign reqReady  = (phase == PH_IDLE) || (phase == PH_SEL);
  assign accept    = reqReady && reqValid;

  always_comb begin
    nextPhase = phase;
    nextCnt   = lastCycle ? cnt : cnt - 1'b1;
    unique case (phase)
      PH_IDLE, PH_SEL: begin
        if (accept) begin
          nextPhase = reqWrite ? PH_SETUP : PH_READ;
          nextCnt   = reqWrite ? SETUP_LOAD : READ_LOAD;
        end else if (phase == PH_SEL) begin
          nextPhase = PH_IDLE;
        end
      end
      PH_SETUP: begin
        if (lastCycle) begin
          nextPhase = PH_PULSE;
          nextCnt   = PULSE_LOAD;
        end
      end
      PH_PULSE: begin
        if (lastCycle) begin
          nextPhase = PH_HOLD;
          nextCnt   = '0;
        end
      end
      PH_HOLD: begin
        nextPhase = PH_SEL;
      end
      PH_READ: begin
        if (lastCycle) begin
          nextPhase = PH_TURN;
          nextCnt   = TURN_LOAD;
        end
      end
      PH_TURN: begin
        if (lastCycle) begin
          nextPhase = PH_SEL;
        end
      end
      default: begin
        nextPhase = PH_IDLE;
        nextCnt   = '0;
      end
    endcase
  end

  always_comb begin
    strb.chipOn  = (nextPhase != PH_IDLE);
    strb.outOn   = (nextPhase == PH_READ);
    strb.writeOn = (nextPhase == PH_PULSE);
    strb.driveOn = (nextPhase == PH_SETUP) || (nextPhase == PH_PULSE) ||
                   (nextPhase == PH_HOLD);
    strb.load    = accept;
    strb.capture = (phase == PH_READ) && lastCycle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= nextPhase;
      cnt   <= nextCnt;
    end
  end

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memDataEn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCeN    <= 1'b1;
      memOeN    <= 1'b1;
      memWeN    <= 1'b1;
      memDataEn <= 1'b0;
    end else begin
      memCeN    <= !strb.chipOn;
      memOeN    <= !strb.outOn;
      memWeN    <= !strb.writeOn;
      memDataEn <= strb.driveOn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr    <= '0;
      memDataOut <= '0;
    end else if (strb.load) begin
      memAddr    <= reqAddr;
      memDataOut <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) begin
        rspData <= memDataIn;
      end
    end
  end

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 4,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SETUP_CYC     = 1,
  parameter int PULSE_CYC     = 1,
  parameter int READ_CYC      = 2,
  parameter int TURN_CYC      = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataEn,
  input  logic [DATA_W-1:0] memDataIn
);

  strobe_t strb;

  sramc_timing_guard #(
    .CLK_PERIOD_PS(CLK_PERIOD_PS),
    .SETUP_CYC    (SETUP_CYC),
    .PULSE_CYC    (PULSE_CYC),
    .READ_CYC     (READ_CYC),
    .TURN_CYC     (TURN_CYC)
  ) guard ();

  sramc_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .READ_CYC (READ_CYC),
    .TURN_CYC (TURN_CYC)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sramc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .memDataIn (memDataIn),
    .memAddr   (memAddr),
    .memDataOut(memDataOut),
    .memCeN    (memCeN),
    .memOeN    (memOeN),
    .memWeN    (memWeN),
    .memDataEn (memDataEn),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 4,
  parameter int TURN_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [DATA_W-1:0] memDataOut,
  input logic              memDataEn
);

  localparam int QW = $clog2(TURN_CYC + 2);
  localparam logic [QW-1:0] QUIET_MAX = QW'(TURN_CYC);

  logic          memDrives;
  logic [QW-1:0] quiet;

  assign memDrives = !memCeN && !memOeN && memWeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quiet <= QUIET_MAX;
    end else if (memDrives) begin
      quiet <= '0;
    end else if (quiet < QUIET_MAX) begin
      quiet <= quiet + 1'b1;
    end
  end

  assert_oe_we_apart_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> memWeN);

  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_we_addr_settled_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> $stable(memAddr) && $stable(memDataOut));

  assert_we_in_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN && memDataEn);

  assert_we_window_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr) && $stable(memDataOut));

  assert_hold_after_we_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDataEn && !memCeN && $stable(memAddr) && $stable(memDataOut));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(memDataEn && memDrives));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rstN)
    memDataEn |-> quiet >= QUIET_MAX);

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> memOeN && memWeN && !memDataEn);

  assert_standby_R8: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> memOeN && memWeN && !memDataEn);

endmodule

bind sramc_top sramc_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .TURN_CYC(TURN_CYC)
) checkerInst (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .memAddr   (memAddr),
  .memCeN    (memCeN),
  .memOeN    (memOeN),
  .memWeN    (memWeN),
  .memDataOut(memDataOut),
  .memDataEn (memDataEn)
);

// File: tb/sramc_top_test.sv
module sramc_top_test;

  localparam int AW = 18;
  localparam int DW = 4;
  localparam int S  = 2;
  localparam int P  = 2;
  localparam int R  = 3;
  localparam int T  = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          rspValid;
  logic [DW-1:0] rspData;
  logic [AW-1:0] memAddr;
  logic          memCeN, memOeN, memWeN, memDataEn;
  logic [DW-1:0] memDataOut;
  logic [DW-1:0] memDataIn = '0;

  int checks = 0;
  int errors = 0;
  int overlapHits = 0;
  int quiet = 100;
  bit done = 0;

  logic [DW-1:0] model [logic [AW-1:0]];
  bit            pendWrite = 0;
  logic [AW-1:0] pendAddr;
  logic [DW-1:0] pendData;

  sramc_top #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(20000),
    .SETUP_CYC(S), .PULSE_CYC(P), .READ_CYC(R), .TURN_CYC(T)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memDataOut(memDataOut), .memDataEn(memDataEn), .memDataIn(memDataIn)
  );

  always #10 clk = ~clk;

  // Memory model: commits a write when the strobe window closes, drives data
  // only while its outputs are enabled, and watches for driver overlap.
  always @(negedge clk) begin
    if (!memCeN && !memWeN) begin
      pendWrite = 1;
      pendAddr  = memAddr;
      pendData  = memDataOut;
    end else if (pendWrite) begin
      model[pendAddr] = pendData;
      pendWrite = 0;
    end
    if (!memCeN && !memOeN && memWeN) begin
      quiet = 0;
      memDataIn = model.exists(memAddr) ? model[memAddr] : '0;
    end else begin
      quiet = quiet + 1;
      memDataIn = '0;
    end
    if (rstN && memDataEn && quiet <= T) overlapHits++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit now, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    if (!now) @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
  endtask

  // Starts at cycle 1 after acceptance, ends in the selected-idle cycle.
  task automatic watchWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int k = 1; k <= S + P + 2; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= S + P + 1) begin
        chk(memCeN == 0 && memOeN == 1, "R4", "write select", {memCeN, memOeN}, 2'b01);
        chk(memWeN == ((k > S && k <= S + P) ? 1'b0 : 1'b1), "R4", "write strobe phase",
            memWeN, (k > S && k <= S + P) ? 0 : 1);
        chk(memDataEn == 1 && memAddr == a && memDataOut == d, "R5", "write drive/addr/data",
            {memDataEn, memAddr, memDataOut}, {1'b1, a, d});
        chk(reqReady == 0, "R9", "ready low during write", reqReady, 0);
      end else begin
        chk(memCeN == 0 && memOeN == 1 && memWeN == 1 && memDataEn == 0 && reqReady == 1,
            "R7", "selected idle after write",
            {memCeN, memOeN, memWeN, memDataEn, reqReady}, 5'b01101);
      end
    end
  endtask

  task automatic watchRead(input logic [AW-1:0] a, input logic [DW-1:0] e);
    for (int k = 1; k <= R + T + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= R) begin
        chk(memCeN == 0 && memOeN == 0 && memWeN == 1 && memDataEn == 0, "R2", "read pins",
            {memCeN, memOeN, memWeN, memDataEn}, 4'b0010);
        chk(memAddr == a, "R2", "read address", memAddr, a);
        chk(rspValid == 0 && reqReady == 0, "R3", "no early response / R9 busy",
            {rspValid, reqReady}, 2'b00);
      end else if (k <= R + T) begin
        chk(memCeN == 0 && memOeN == 1 && memDataEn == 0, "R6", "turnaround pins",
            {memCeN, memOeN, memDataEn}, 3'b010);
        chk(rspValid == (k == R + 1), "R3", "response pulse", rspValid, k == R + 1);
        if (k == R + 1) chk(rspData == e, "R3", "read data", rspData, e);
      end else begin
        chk(memCeN == 0 && memOeN == 1 && memWeN == 1 && memDataEn == 0 && reqReady == 1
            && rspValid == 0, "R7", "selected idle after read",
            {memCeN, memOeN, memWeN, memDataEn, reqReady, rspValid}, 6'b011010);
      end
    end
  endtask

  task automatic expectStandby(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      chk(memCeN == 1 && memOeN == 1 && memWeN == 1 && memDataEn == 0 && reqReady == 1,
          "R8", "standby", {memCeN, memOeN, memWeN, memDataEn, reqReady}, 5'b11101);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(memCeN == 1 && memOeN == 1 && memWeN == 1 && memDataEn == 0 && rspValid == 0
        && reqReady == 1, "R1", "during reset",
        {memCeN, memOeN, memWeN, memDataEn, rspValid, reqReady}, 6'b111001);
    rstN = 1;
    @(negedge clk);
    chk(memCeN == 1 && memOeN == 1 && memWeN == 1 && memDataEn == 0 && rspValid == 0
        && reqReady == 1, "R1", "after reset",
        {memCeN, memOeN, memWeN, memDataEn, rspValid, reqReady}, 6'b111001);
  endtask

  task automatic testWriteRead();
    issue(0, 1, 18'h00000, 4'h5);
    watchWrite(18'h00000, 4'h5);
    expectStandby(2);
    issue(0, 0, 18'h00000, 4'h0);
    watchRead(18'h00000, 4'h5);
    expectStandby(2);
  endtask

  task automatic testAddrEdges();
    issue(0, 1, 18'h3FFFF, 4'hA);
    watchWrite(18'h3FFFF, 4'hA);
    expectStandby(1);
    issue(0, 1, 18'h00001, 4'h3);
    watchWrite(18'h00001, 4'h3);
    expectStandby(1);
    issue(0, 0, 18'h3FFFF, 4'h0);
    watchRead(18'h3FFFF, 4'hA);   // R10 top address
    expectStandby(1);
    issue(0, 0, 18'h00000, 4'h0);
    watchRead(18'h00000, 4'h5);   // R10 neighbour write left it alone
    expectStandby(1);
    issue(0, 0, 18'h12345, 4'h0);
    watchRead(18'h12345, 4'h0);   // R10 never written
    expectStandby(1);
  endtask

  // R7 and R9: next request held during the write, accepted in the gap cycle.
  task automatic testBackToBack();
    issue(0, 1, 18'h2AAAA, 4'h9);
    reqValid = 1; reqWrite = 0; reqAddr = 18'h15555; reqWdata = 4'h6;
    watchWrite(18'h2AAAA, 4'h9);
    reqAddr = 18'h2AAAA;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    watchRead(18'h2AAAA, 4'h9);
    reqValid = 1; reqWrite = 0; reqAddr = 18'h3FFFF;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    watchRead(18'h3FFFF, 4'hA);
    reqValid = 1; reqWrite = 1; reqAddr = 18'h00002; reqWdata = 4'hC;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    watchWrite(18'h00002, 4'hC);
    expectStandby(1);
    issue(0, 0, 18'h00002, 4'h0);
    watchRead(18'h00002, 4'hC);
    expectStandby(3);
  endtask

  task automatic finishRun();
    chk(overlapHits == 0, "R6", "driver overlap or short turnaround cycles", overlapHits, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testWriteRead();
    testAddrEdges();
    testBackToBack();
    done = 1;
    finishRun();
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule